// File: doc/BRIEF.md
# Bit Extract and Deposit Unit

This unit performs the two bitwise permutations of a 64-bit operand under a mask. Extract gathers the operand bits that sit at the set positions of the mask and packs them, in ascending order, into the low end of the result. Deposit does the reverse: it takes the low operand bits in order and scatters them to the set positions of the mask. All other result bits are zero.

The unit does not count anything itself. Alongside the mask, the request carries six distance slices computed upstream. For each bit position, these slices give the number of zero mask bits below that position, stored one count bit per slice. Each slice controls one conditional-shift stage with a power-of-two distance. Extract runs the stages from the shortest distance to the longest. Deposit runs them from the longest to the shortest. The result is registered and appears one cycle after the request.

Top module: `bitperm_unit`

## Requirements
- R1: With `req_op_i` = 0 (extract), result bit k equals the operand bit at the k-th lowest set position of the mask (counting from k = 0), for k below P = popcount(mask). Result bits at k >= P are zero.
- R2: With `req_op_i` = 1 (deposit), at the k-th lowest set position of the mask the result holds operand bit k. Result bits where the mask is zero are zero.
- R3: In extract mode, operand bits at positions where the mask is zero have no effect on the result.
- R4: In deposit mode, operand bits at index P or above have no effect on the result. This includes the case P = 63.
- R5: With an all-ones mask (P = 64), both modes return the operand unchanged. In particular, deposit keeps all 64 bits and does not clear them.
- R6: With an all-zero mask, the result is zero in both modes.
- R7: `res_valid_o` equals `req_valid_i` delayed by exactly one clock cycle. `res_data_o` changes only on a cycle that follows an accepted request and holds its value otherwise. While `rst_ni` is low, both outputs are zero.
- R8: Bit j of slice i, at `req_dist_i[i*64 + j]`, is bit i of the count of zero mask bits at positions below j. The result is correct whenever the slices follow this encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_op_i | input | 1 | 0 = extract, 1 = deposit |
| req_data_i | input | 64 | Operand |
| req_mask_i | input | 64 | Selection mask |
| req_dist_i | input | 384 | Six distance slices; slice i occupies bits [i*64 +: 64] |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_data_o | output | 64 | Result |

## Verification
The hardest condition to create is a deposit whose pre-mask sits at the ends of its range. With P = 64 the low-bit mask must cover the whole word. With P = 63 exactly one bit must be cut off. Random masks almost never land on these population counts. The stimulus therefore applies the all-ones mask and a mask with a single cleared bit directly, with dirty operands above the boundary. Random masks are also used together with their complements and with OR-combined dense variants, so that long runs of zeros drive the large shift distances.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
  typedef enum logic {
    OP_EXTRACT = 1'b0,
    OP_DEPOSIT = 1'b1
  } bp_op_e;
endpackage

// File: rtl/bitperm_premask.sv
module bitperm_premask #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] ext_o,
  output logic [W-1:0] dep_o
);
  logic [CW-1:0] pop;
  logic [W-1:0]  low_keep;

  always_comb begin
    pop = '0;
    for (int j = 0; j < W; j++) pop = pop + {{(CW-1){1'b0}}, mask_i[j]};
  end

  // thermometer of the population count: covers pop == W without wrap
  for (genvar j = 0; j < W; j++) begin : g_keep
    assign low_keep[j] = (CW'(j) < pop);
  end

  assign ext_o = data_i & mask_i;
  assign dep_o = data_i & low_keep;
endmodule

// File: rtl/bitperm_stage.sv
module bitperm_stage #(
  parameter int W       = 64,
  parameter int SH      = 1,
  parameter bit DEPOSIT = 1'b0
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] data_o
);
  if (DEPOSIT) begin : g_dep
    logic [W-1:0] sel_src;
    // slice marks destinations; move it back to the source positions
    assign sel_src = sel_i >> SH;
    // moved and stationary sets are disjoint, so add equals or
    assign data_o  = (data_i & ~sel_src) + ((data_i & sel_src) << SH);
  end else begin : g_ext
    assign data_o  = (data_i & ~sel_i) | ((data_i & sel_i) >> SH);
  end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int W   = 64,
  localparam int NS = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_op_i,
  input  logic [W-1:0]  req_data_i,
  input  logic [W-1:0]  req_mask_i,
  input  logic [NS*W-1:0] req_dist_i,
  output logic          res_valid_o,
  output logic [W-1:0]  res_data_o
);
  logic [W-1:0] ext_c [NS+1];
  logic [W-1:0] dep_c [NS+1];
  logic [W-1:0] res_d;
  logic [W-1:0] res_q;
  logic         vld_q;
  bp_op_e       op;

  assign op = bp_op_e'(req_op_i);

  bitperm_premask #(.W(W)) i_premask (
    .data_i (req_data_i),
    .mask_i (req_mask_i),
    .ext_o  (ext_c[0]),
    .dep_o  (dep_c[0])
  );

  for (genvar k = 0; k < NS; k++) begin : g_chain
    localparam int DI = NS - 1 - k;
    bitperm_stage #(.W(W), .SH(1 << k), .DEPOSIT(1'b0)) i_ext (
      .data_i (ext_c[k]),
      .sel_i  (req_dist_i[k*W +: W]),
      .data_o (ext_c[k+1])
    );
    bitperm_stage #(.W(W), .SH(1 << DI), .DEPOSIT(1'b1)) i_dep (
      .data_i (dep_c[k]),
      .sel_i  (req_dist_i[DI*W +: W]),
      .data_o (dep_c[k+1])
    );
  end

  assign res_d = (op == OP_DEPOSIT) ? dep_c[NS] : ext_c[NS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) res_q <= res_d;
    end
  end

  assign res_valid_o = vld_q;
  assign res_data_o  = res_q;

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!res_valid_o && $stable(res_data_o)));
  p_ext_high_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_op_i) |=>
      ((res_data_o >> $countones($past(req_mask_i))) == '0));
  p_ext_pop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_op_i) |=>
      ($countones(res_data_o) == $countones($past(req_data_i & req_mask_i))));
  p_dep_in_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i) |=> ((res_data_o & ~$past(req_mask_i)) == '0));
  p_full_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (&req_mask_i)) |=> (res_data_o == $past(req_data_i)));
  p_zero_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_mask_i == '0)) |=> (res_data_o == '0));
endmodule

// File: tb/test_bitperm_unit.sv
`timescale 1ns/1ps
module test_bitperm_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_op_i = 1'b0;
  logic [63:0]  req_data_i = '0;
  logic [63:0]  req_mask_i = '0;
  logic [383:0] req_dist_i = '0;
  logic         res_valid_o;
  logic [63:0]  res_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit           exp_v = 1'b0;
  logic [63:0]  exp_d = '0;
  string        exp_tag = "R7";

  always #2.5 clk_i = ~clk_i;

  bitperm_unit i_bitperm_unit (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_data_i,
    .req_mask_i, .req_dist_i, .res_valid_o, .res_data_o
  );

  // R8: slice i bit j = bit i of zero-mask count below j
  function automatic logic [383:0] gen_dist(logic [63:0] m);
    logic [383:0] s = '0;
    int z = 0;
    for (int j = 0; j < 64; j++) begin
      for (int i = 0; i < 6; i++) s[i*64 + j] = z[i];
      if (!m[j]) z++;
    end
    return s;
  endfunction

  function automatic logic [63:0] ref_ext(logic [63:0] d, logic [63:0] m);
    logic [63:0] r = '0;
    int k = 0;
    for (int j = 0; j < 64; j++) if (m[j]) begin r[k] = d[j]; k++; end
    return r;
  endfunction

  function automatic logic [63:0] ref_dep(logic [63:0] d, logic [63:0] m);
    logic [63:0] r = '0;
    int k = 0;
    for (int j = 0; j < 64; j++) if (m[j]) begin r[j] = d[k]; k++; end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit op, logic [63:0] d, logic [63:0] m, string tag);
    @(negedge clk_i);
    chk("R7 valid", {63'b0, res_valid_o}, {63'b0, exp_v});
    chk(exp_v ? exp_tag : "R7 hold", res_data_o, exp_d);
    req_valid_i = v;
    req_op_i    = op;
    req_data_i  = d;
    req_mask_i  = m;
    req_dist_i  = gen_dist(m);
    exp_v       = v;
    if (v) begin
      exp_d   = op ? ref_dep(d, m) : ref_ext(d, m);
      exp_tag = tag;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] m, m2;
    logic [63:0] ms [4];
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R7 reset valid", {63'b0, res_valid_o}, 64'd0);
    chk("R7 reset data", res_data_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners
    step(1, 0, 64'hDEAD_BEEF_0123_4567, '1, "R5 extract full mask");
    step(1, 1, 64'hDEAD_BEEF_0123_4567, '1, "R5 deposit full mask");
    step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R6 extract zero mask");
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R6 deposit zero mask");
    step(0, 1, 64'h1234, 64'hF0, "R7 idle");
    step(0, 0, 64'h0, 64'h0, "R7 idle");
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF7, "R4 deposit P=63");
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFE5, 64'h8000_0400_0020_0101, "R4 deposit dirty high");
    step(1, 1, 64'h0000_0000_0000_0005, 64'h8000_0400_0020_0101, "R4 deposit clean high");
    step(1, 0, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, "R3 extract masked-off ones");
    step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, "R1 extract ends");
    step(1, 1, 64'h3, 64'h8000_0000_0000_0001, "R2 deposit ends");

    for (int r = 0; r < 12; r++) begin
      m  = {$urandom, $urandom};
      m2 = m | {$urandom, $urandom} | {$urandom, $urandom};
      ms[0] = m; ms[1] = ~m; ms[2] = m2; ms[3] = ~m2;
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [63:0] d;
          d = {$urandom, $urandom};
          step(1, 0, d, ms[i], "R1/R8 extract random");
          step(1, 1, d, ms[i], "R2/R8 deposit random");
          if (j == 7) step(0, 0, d, ms[i], "R7 idle");
        end
      end
    end
    step(0, 0, 64'h0, 64'h0, "R7 idle");
    step(0, 0, 64'h0, 64'h0, "R7 idle");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule